// File: doc/BRIEF.md
# Serial CRC-8 Transfer Validator

This block is a bit-serial checksum engine for a single-wire memory tag link. Every bit that crosses the bus is presented on a data input with a one-cycle valid strobe. The engine folds each accepted bit into an 8-bit remainder of the polynomial x^8 + x^5 + x^4 + 1. Bits arrive least significant bit first. The remainder is visible in parallel at all times, so a transmitter can take the byte and shift it out after the last data byte of a transfer.

A clear input starts every use and also selects the mode. In transaction mode the engine accumulates without limit over the command, address and data bytes that the protocol layer feeds it. For write transfers these are command, address and data. For read transfers they are command and address only. The controller clears the engine again at every page boundary and before the status field. In identifier mode the engine takes a 64-bit identifier. It computes the remainder over the first 56 bits and then freezes it. It compares the last 8 received bits against the frozen value and raises a result flag. A mismatch only shows in the flag. The block never stalls or gates the command sequence.

The controller is a four-state machine. After reset or a clear in transaction mode, the state is `ST_TXN`. A clear in identifier mode goes to `ST_ID_CALC`. The 56th accepted bit moves it to `ST_ID_CMP`. The 8th compared bit moves it to `ST_ID_DONE`. From any state, a clear returns the machine to `ST_TXN` or `ST_ID_CALC`, as `mode_id` selects. `ST_TXN` and `ST_ID_DONE` have no exit other than a clear.

Top module: `ser_crc8_validator`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted bit, `crc_out` is 0x00 and `id_valid` and `id_match` are 0.
- R2: In transaction mode, each bit accepted on a clock edge updates the remainder: the feedback is the input bit XOR remainder bit 0; the remainder shifts right by one; when the feedback is 1 it is XORed with 0x8C. This is the reflected form of x^8+x^5+x^4+1.
- R3: On a cycle with `bit_vld` low and `clr` low, `crc_out` keeps its value.
- R4: `clr` high sets `crc_out` to 0x00 at the next edge and takes priority over a bit offered in the same cycle. The value of `mode_id` sampled with `clr` selects identifier mode (1) or transaction mode (0).
- R5: In identifier mode, `crc_out` after 56 accepted bits is the remainder of those bits. It stays frozen through the next 8 bits and any bits after them.
- R6: In identifier mode, `id_valid` goes high right after the edge that accepts the 64th bit. At that point `id_match` is 1 exactly when bits 57 to 64 equal the frozen remainder taken LSB first (bit 57 compared with remainder bit 0). `id_match` is never high while `id_valid` is low.
- R7: The check result only flags. In `ST_ID_DONE`, further bits change neither `crc_out` nor the result. In transaction mode, `id_valid` stays 0 whatever data arrives.
- R8: In transaction mode, feeding a byte stream followed by its own remainder (LSB first) leaves `crc_out` at 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | High for one cycle per bus bit to be accepted |
| bit_in | input | 1 | Bus bit, valid with `bit_vld` |
| clr | input | 1 | Synchronous clear and mode load |
| mode_id | input | 1 | Mode sampled with `clr`: 1 identifier check, 0 transaction |
| crc_out | output | 8 | Current remainder, readable in parallel |
| id_valid | output | 1 | Identifier check complete |
| id_match | output | 1 | Stored checksum matched the computed one |

## Verification
The bench targets the 56/64 boundary of identifier mode. A counter off by one there would freeze the remainder one bit early or late, so the known-good identifier would report a mismatch. It corrupts a single checksum bit to show that the comparison covers all eight positions. It feeds extra bits after completion to catch a design that keeps shifting or re-arms itself. It drives a clear together with a bit to expose a design that lets the bit through. Randomly gapped transaction streams and the zero-residue test catch a design that reverses the shift direction, misplaces a feedback tap, or advances on idle cycles.

// File: rtl/ser_crc8_pkg.sv
package ser_crc8_pkg;

    typedef enum logic [1:0] {
        ST_TXN     = 2'd0,
        ST_ID_CALC = 2'd1,
        ST_ID_CMP  = 2'd2,
        ST_ID_DONE = 2'd3
    } crc_state_e;

endpackage

// File: rtl/ser_crc8_step.sv
// One LSB-first shift of a reflected CRC register.
module ser_crc8_step #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb = crc_i[0] ^ bit_i;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == W - 1) begin : g_top
            assign crc_o[i] = POLY[i] & fb;
        end else begin : g_mid
            assign crc_o[i] = crc_i[i+1] ^ (POLY[i] & fb);
        end
    end
endmodule

// File: rtl/ser_crc8_bitcnt.sv
// Bit position counter shared by the payload and compare phases.
module ser_crc8_bitcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/ser_crc8_idcmp.sv
// Streams received checksum bits against the frozen remainder.
module ser_crc8_idcmp #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_i,
    input  logic [W-1:0]     crc_i,
    input  logic [IDX_W-1:0] idx,
    output logic             miss
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss <= 1'b0;
        end else if (clr) begin
            miss <= 1'b0;
        end else if (en && (bit_i != crc_i[idx])) begin
            miss <= 1'b1;
        end
    end
endmodule

// File: rtl/ser_crc8_validator.sv
module ser_crc8_validator
    import ser_crc8_pkg::*;
#(
    parameter int              CRC_W   = 8,
    parameter logic [CRC_W-1:0] POLY_R = 8'h8C,
    parameter int              ID_BITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             clr,
    input  logic             mode_id,
    output logic [CRC_W-1:0] crc_out,
    output logic             id_valid,
    output logic             id_match
);
    localparam int PAY_BITS = ID_BITS - CRC_W;
    localparam int CNT_W    = $clog2(PAY_BITS);
    localparam int IDX_W    = $clog2(CRC_W);

    crc_state_e       state_q, state_d;
    logic [CRC_W-1:0] crc_q, crc_step;
    logic [CNT_W-1:0] cnt;
    logic             last_pay, last_cmp, phase_wrap;
    logic             crc_en, cmp_en, miss;

    assign last_pay   = (cnt == CNT_W'(PAY_BITS - 1));
    assign last_cmp   = (cnt == CNT_W'(CRC_W - 1));
    assign phase_wrap = bit_vld &&
                        (((state_q == ST_ID_CALC) && last_pay) ||
                         ((state_q == ST_ID_CMP)  && last_cmp));
    assign crc_en = bit_vld && ((state_q == ST_TXN) || (state_q == ST_ID_CALC));
    assign cmp_en = bit_vld && (state_q == ST_ID_CMP);

    ser_crc8_step #(.W(CRC_W), .POLY(POLY_R)) u_step (
        .crc_i (crc_q),
        .bit_i (bit_in),
        .crc_o (crc_step)
    );

    ser_crc8_bitcnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr || phase_wrap),
        .inc   (bit_vld && ((state_q == ST_ID_CALC) || (state_q == ST_ID_CMP))),
        .cnt   (cnt)
    );

    ser_crc8_idcmp #(.W(CRC_W), .IDX_W(IDX_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (cmp_en),
        .bit_i (bit_in),
        .crc_i (crc_q),
        .idx   (cnt[IDX_W-1:0]),
        .miss  (miss)
    );

    // Remainder register: clear wins over an offered bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (crc_en) begin
            crc_q <= crc_step;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TXN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = mode_id ? ST_ID_CALC : ST_TXN;
        end else begin
            unique case (state_q)
                ST_TXN:     state_d = ST_TXN;
                ST_ID_CALC: if (bit_vld && last_pay) state_d = ST_ID_CMP;
                ST_ID_CMP:  if (bit_vld && last_cmp) state_d = ST_ID_DONE;
                ST_ID_DONE: state_d = ST_ID_DONE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        crc_out  = crc_q;
        id_valid = (state_q == ST_ID_DONE);
        id_match = id_valid && !miss;
    end
endmodule

// File: rtl/ser_crc8_checker.sv
module ser_crc8_checker
    import ser_crc8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       clr,
    input logic [7:0] crc_out,
    input logic       id_valid,
    input logic       id_match,
    input crc_state_e state_q
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |-> (crc_out == 8'h00 && !id_valid && !id_match));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !clr) |=> $stable(crc_out));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == 8'h00));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ID_CMP || state_q == ST_ID_DONE) && !clr) |=> $stable(crc_out));

    assert_valid_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_valid) |-> $past(bit_vld));

    assert_match_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !id_match);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !clr) |=> (id_valid && $stable(id_match)));

    assert_txn_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TXN) |-> !id_valid);
endmodule

bind ser_crc8_validator ser_crc8_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .clr      (clr),
    .crc_out  (crc_out),
    .id_valid (id_valid),
    .id_match (id_match),
    .state_q  (state_q)
);

// File: tb/ser_crc8_validator_bench.sv
`timescale 1ns/1ps
module ser_crc8_validator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       clr = 1'b0;
    logic       mode_id = 1'b0;
    logic [7:0] crc_out;
    logic       id_valid, id_match;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_crc8_validator u_ser_crc8_validator (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .clr(clr), .mode_id(mode_id), .crc_out(crc_out),
        .id_valid(id_valid), .id_match(id_match)
    );

    function automatic logic [7:0] ref_step(logic [7:0] c, logic b);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ 8'h8C;
        return c;
    endfunction

    function automatic logic [7:0] ref_byte(logic [7:0] c, logic [7:0] d);
        for (int i = 0; i < 8; i++) c = ref_step(c, d[i]);
        return c;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] d);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
    endtask

    task automatic do_clr(logic m);
        @(negedge clk);
        clr = 1'b1;
        mode_id = m;
        @(negedge clk);
        clr = 1'b0;
        mode_id = 1'b0;
    endtask

    // Feeds a full identifier; returns outputs after the last bit.
    task automatic run_id(logic [55:0] pay, logic [7:0] tail, logic [7:0] exp_crc, bit exp_m);
        do_clr(1'b1);
        for (int i = 0; i < 56; i++) send_bit(pay[i]);
        check(crc_out == exp_crc, "R5", crc_out, exp_crc);
        for (int i = 0; i < 8; i++) send_bit(tail[i]);
        check(crc_out == exp_crc, "R5", crc_out, exp_crc);
        check(id_valid == 1'b1, "R6", id_valid, 1);
        check(id_match == exp_m, "R6", id_match, exp_m);
    endtask

    initial begin
        logic [7:0]  m;
        logic [55:0] pay;
        logic [7:0]  good, tail;
        int unsigned r;
        r = $urandom(32'h5EED);

        idle(3);
        check(crc_out == 8'h00, "R1", crc_out, 0);
        check(!id_valid && !id_match, "R1", {id_valid, id_match}, 0);
        rst_n = 1'b1;
        idle(2);
        check(crc_out == 8'h00, "R1", crc_out, 0);

        // Directed known identifier: payload 02 1C B8 01 00 00 00, checksum A2.
        pay = 56'h000000_01B8_1C02;
        run_id(pay, 8'hA2, 8'hA2, 1'b1);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        check(crc_out == 8'hA2, "R7", crc_out, 8'hA2);
        check(id_valid && id_match, "R7", {id_valid, id_match}, 3);

        // Each single-bit corruption of the checksum is detected.
        for (int k = 0; k < 8; k++) begin
            run_id(pay, 8'hA2 ^ (8'h01 << k), 8'hA2, 1'b0);
        end

        // Random identifiers, half corrupted.
        for (int t = 0; t < 20; t++) begin
            pay  = {$urandom, $urandom};
            m    = 8'h00;
            for (int b = 0; b < 7; b++) m = ref_byte(m, pay[b*8 +: 8]);
            good = m;
            tail = ($urandom % 2) ? good : (good ^ 8'($urandom % 255 + 1));
            run_id(pay, tail, good, tail == good);
        end

        // Clear with a bit in the same cycle: bit dropped, transaction mode.
        @(negedge clk);
        clr = 1'b1; mode_id = 1'b0; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clr = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        check(crc_out == 8'h00, "R4", crc_out, 0);
        check(!id_valid, "R4", id_valid, 0);

        // Random transactions with idle gaps and residue check.
        for (int t = 0; t < 30; t++) begin
            int nb;
            do_clr(1'b0);
            m  = 8'h00;
            nb = 1 + int'($urandom % 12);
            for (int b = 0; b < nb; b++) begin
                logic [7:0] d;
                d = 8'($urandom);
                for (int i = 0; i < 8; i++) begin
                    send_bit(d[i]);
                    m = ref_step(m, d[i]);
                    if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
                end
                check(crc_out == m, "R2", crc_out, m);
                check(!id_valid, "R7", id_valid, 0);
            end
            idle(4);
            check(crc_out == m, "R3", crc_out, m);
            send_byte(m);
            check(crc_out == 8'h00, "R8", crc_out, 0);
        end

        // Clear mid-identifier returns to transaction mode.
        do_clr(1'b1);
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        do_clr(1'b0);
        check(crc_out == 8'h00, "R4", crc_out, 0);
        send_byte(8'h5A);
        m = ref_byte(8'h00, 8'h5A);
        check(crc_out == m, "R2", crc_out, m);
        for (int i = 0; i < 70; i++) send_bit(1'b0);
        check(!id_valid, "R7", id_valid, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule